// File: doc/BRIEF.md
# Tick-Driven Count/Compare Timer

The block keeps a free-running 32-bit counter and a 32-bit match value. Each cycle in which the tick-enable input is high, the counter advances by one, so the tick input sets the counting rate (nominally one increment per 10 ns period at 100 MHz). When a tick brings the counter onto the match value, a timer request is raised. The request stays raised until software writes a new match value. Writing the match value is the only way to acknowledge it.

Software reaches both registers through a single-cycle write port and a combinational read port. Each port has a one-bit register select. The request appears on one fixed position of a request-line vector that feeds the interrupt logic, and every other line in that vector stays low. The registers come out of reset with the counter one ahead of the match value. The first match therefore happens only after the counter has wrapped around.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the counter reads 1, the match value reads 0 and no request line is high.
- R2: In a cycle with tick high and no counter write, the counter increases by exactly one at the next clock edge. With tick low and no counter write, the counter holds.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000 without any other effect.
- R4: At the clock edge where a tick moves the counter onto the match value, the timer request rises, unless the match value is written in that same cycle.
- R5: Once raised, the request stays high while the counter moves past the match value, and also across counter writes. It stays high until the match value is written.
- R6: A write with select 1 loads the match value and clears the request at the next edge. It leaves the counter unchanged, or advances it by one if tick is also high.
- R7: A write with select 0 loads the counter and keeps the match value. If tick is high in the same cycle, the written value wins.
- R8: A write that makes the counter equal to the match value raises no request. The next request needs a tick that lands on the match value again.
- R9: The request vector is 8 lines wide. The timer drives line 7 only, and lines 0 to 6 are always 0.
- R10: The read port returns the counter when the read select is 0 and the match value when it is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-rate enable; the counter advances by one per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 selects the counter, 1 selects the match value |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 selects the counter, 1 selects the match value |
| rdData | output | 32 | Read data for the selected register |
| reqLines | output | 8 | Interrupt request vector; the timer request sits on line 7 |

## Verification
On every cycle, the assertions check how the counter steps, the priority of counter writes over ticks, how the request is set, held and cleared, and that the request only rises after a tick. They also check that at most one request line is active. Only the bench's scenarios can show the reset values, the wrap from the top value to zero, and the cases where a write makes the two registers equal. They also show the values seen through the read port. All of these need a specific sequence of register values rather than a property between neighbouring cycles.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

  typedef enum logic {
    SEL_COUNT   = 1'b0,
    SEL_COMPARE = 1'b1
  } regSel_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic ldCount;
    logic incCount;
    logic ldCompare;
  } dpStrobe_t;

endpackage

// File: rtl/tmt_ctrl.sv
module tmt_ctrl
  import tmt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      wrEn,
  input  logic      wrSel,
  input  logic      hitNext,
  output dpStrobe_t strobe,
  output logic      irqPend
);

  regSel_e target;

  always_comb begin
    target           = regSel_e'(wrSel);
    strobe.ldCount   = wrEn && (target == SEL_COUNT);
    strobe.ldCompare = wrEn && (target == SEL_COMPARE);
    // A counter write overrides a tick in the same cycle.
    strobe.incCount  = tickEn && !strobe.ldCount;
  end

  // Request flag: cleared only by a compare write, set only by a tick landing on the match.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPend <= 1'b0;
    end else if (strobe.ldCompare) begin
      irqPend <= 1'b0;
    end else if (strobe.incCount && hitNext) begin
      irqPend <= 1'b1;
    end
  end

endmodule

// File: rtl/tmt_datapath.sv
module tmt_datapath
  import tmt_pkg::*;
#(
  parameter int unsigned          CNT_W       = 32,
  parameter logic [CNT_W-1:0]     RST_COUNT   = 1,
  parameter logic [CNT_W-1:0]     RST_COMPARE = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] compareQ,
  output logic             hitNext
);

  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] countInc;

  assign countInc = countQ + STEP;   // modulo 2^CNT_W, no carry kept
  assign hitNext  = (countInc == compareQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= RST_COUNT;
    end else if (strobe.ldCount) begin
      countQ <= wrData;
    end else if (strobe.incCount) begin
      countQ <= countInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compareQ <= RST_COMPARE;
    end else if (strobe.ldCompare) begin
      compareQ <= wrData;
    end
  end

  always_comb begin
    unique case (regSel_e'(rdSel))
      SEL_COUNT:   rdData = countQ;
      SEL_COMPARE: rdData = compareQ;
      default:     rdData = countQ;
    endcase
  end

endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmt_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned REQ_LINES  = 8,
  parameter int unsigned TIMER_LINE = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [CNT_W-1:0]     wrData,
  input  logic                 rdSel,
  output logic [CNT_W-1:0]     rdData,
  output logic [REQ_LINES-1:0] reqLines
);

  dpStrobe_t        strobe;
  logic             hitNext;
  logic             irqPend;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] compareQ;

  tmt_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .hitNext (hitNext),
    .strobe  (strobe),
    .irqPend (irqPend)
  );

  tmt_datapath #(
    .CNT_W       (CNT_W),
    .RST_COUNT   ({{(CNT_W-1){1'b0}}, 1'b1}),
    .RST_COMPARE ({CNT_W{1'b0}})
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdSel    (rdSel),
    .rdData   (rdData),
    .countQ   (countQ),
    .compareQ (compareQ),
    .hitNext  (hitNext)
  );

  // Route the timer request onto its fixed line; all other lines tie low.
  for (genvar i = 0; i < REQ_LINES; i++) begin : g_line
    if (i == TIMER_LINE) begin : g_timer
      assign reqLines[i] = irqPend;
    end else begin : g_idle
      assign reqLines[i] = 1'b0;
    end
  end

endmodule

// File: rtl/tick_match_timer_chk.sv
module tick_match_timer_chk #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned REQ_LINES  = 8,
  parameter int unsigned TIMER_LINE = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickEn,
  input logic                 wrEn,
  input logic                 wrSel,
  input logic [CNT_W-1:0]     wrData,
  input logic [REQ_LINES-1:0] reqLines,
  input logic [CNT_W-1:0]     countQ,
  input logic [CNT_W-1:0]     compareQ
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic irq;
  assign irq = reqLines[TIMER_LINE];

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !(wrEn && !wrSel)) |=> (countQ == $past(countQ) + ONE));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !(wrEn && !wrSel)) |=> $stable(countQ));

  assert_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !wrEn && (countQ + ONE == compareQ)) |=> irq);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && wrSel)) |=> irq);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> (!irq && compareQ == $past(wrData)));

  assert_count_wr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (countQ == $past(wrData) && $stable(compareQ)));

  assert_rise_needs_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(tickEn) && !$past(wrEn)));

  assert_one_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqLines));

endmodule

bind tick_match_timer tick_match_timer_chk #(
  .CNT_W      (CNT_W),
  .REQ_LINES  (REQ_LINES),
  .TIMER_LINE (TIMER_LINE)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .reqLines (reqLines),
  .countQ   (countQ),
  .compareQ (compareQ)
);

// File: tb/tick_match_timer_tb_top.sv
module tick_match_timer_tb_top;

  typedef struct {
    string       tag;
    logic [31:0] rdExp;
    logic        irqExp;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic [7:0]  reqLines;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  item_t expQ[$];

  logic [31:0] mCount;
  logic [31:0] mCompare;
  logic        mIrq;

  always #4 clk = ~clk;   // 125 MHz

  tick_match_timer dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .rdSel    (rdSel),
    .rdData   (rdData),
    .reqLines (reqLines)
  );

  function automatic void pushExp(string tag);
    item_t it;
    it.tag    = tag;
    it.rdExp  = rdSel ? mCompare : mCount;
    it.irqExp = mIrq;
    expQ.push_back(it);
  endfunction

  // Driver: one cycle of stimulus, model update, expected item queued.
  task automatic step(string tag, bit tick, bit wr, bit sel, logic [31:0] data, bit rsel);
    @(negedge clk);
    #1;
    tickEn = tick; wrEn = wr; wrSel = sel; wrData = data; rdSel = rsel;
    if (wr && sel) begin
      mCompare = data;
      mIrq     = 1'b0;
      if (tick) mCount = mCount + 1;
    end else if (wr) begin
      mCount = data;
    end else if (tick) begin
      mCount = mCount + 1;
      if (mCount == mCompare) mIrq = 1'b1;
    end
    @(posedge clk);
    #1;
    tickEn = 1'b0; wrEn = 1'b0;
    pushExp(tag);
  endtask

  // Monitor: compares read data and request vector against queued expectations.
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      logic [7:0] linesExp;
      it = expQ.pop_front();
      linesExp = it.irqExp ? 8'h80 : 8'h00;
      total++;
      if (rdData !== it.rdExp) begin
        bad++;
        $display("FAIL %s rdData actual=%h expected=%h", it.tag, rdData, it.rdExp);
      end
      total++;
      if (reqLines !== linesExp) begin
        bad++;
        $display("FAIL %s/R9 reqLines actual=%b expected=%b", it.tag, reqLines, linesExp);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    mCount = 32'd1; mCompare = 32'd0; mIrq = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    pushExp("R1 count after reset");
    step("R1 compare after reset R10", 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step("R2 tick", 1, 0, 0, 0, 0);
    step("R2 hold", 0, 0, 0, 0, 0);
    step("R6 compare load R10", 0, 1, 1, 32'd8, 1);
    step("R6 count kept", 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R4 count to match", 1, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) step("R5 sticky past match", 1, 0, 0, 0, 0);
    step("R7 count write beats tick", 1, 1, 0, 32'd100, 0);
    step("R7 compare kept R5", 0, 0, 0, 0, 1);
    step("R6 clear by compare write", 0, 1, 1, 32'd100, 0);
    for (int i = 0; i < 3; i++) step("R8 no match on equal write", 1, 0, 0, 0, 0);
    step("R7 load near top", 0, 1, 0, 32'hFFFF_FFFE, 0);
    step("R3 to top", 1, 0, 0, 0, 0);
    step("R3 wrap to zero", 1, 0, 0, 0, 0);
    step("R6 compare 3", 0, 1, 1, 32'd3, 1);
    for (int i = 0; i < 3; i++) step("R4 match after wrap", 1, 0, 0, 0, 0);
    step("R6 compare write with tick", 1, 1, 1, 32'd4, 0);
    step("R6 no match on same-cycle tick", 0, 0, 0, 0, 1);
    step("R8 compare 20", 0, 1, 1, 32'd20, 1);
    step("R8 count write equals compare", 0, 1, 0, 32'd20, 0);
    for (int i = 0; i < 2; i++) step("R8 silent after equal write", 1, 0, 0, 0, 0);
    step("R8 count 18", 0, 1, 0, 32'd18, 0);
    step("R8 tick 19", 1, 0, 0, 0, 0);
    step("R4 tick lands on 20", 1, 0, 0, 0, 0);
    step("R5 count write keeps request", 0, 1, 0, 32'd5, 0);
    step("R10 read compare", 0, 0, 0, 0, 1);
    @(negedge clk);
    @(negedge clk);
    finish();
  end

endmodule